// File: doc/BRIEF.md
# SPI Serial Flash Command Decoder

This block is the slave-side front end of a page-erasable serial flash. It watches the chip-select, serial-clock and serial-data-in pins and drives serial data out with a separate output enable. It collects a one-byte instruction and then any three address bytes and a dummy byte. It answers identification, status and array-read instructions itself, and it passes page write, page program, page erase and sector erase requests to a separate write/erase sequencer. It also holds the write-enable latch and a deep power-down mode.

The pins are sampled into the system clock domain through a short synchroniser, so the serial clock must stay high and low for several system clocks in each phase. Array reads use a byte-wide request port. The memory returns `mem_rdata` on the cycle after `mem_req`. Data bytes of a write or program instruction are streamed to the sequencer as they arrive. One `op_valid` pulse at the rising edge of chip select commits the request. If no pulse comes, the streamed bytes must be dropped.

Top module: `sfcd_front`

## Requirements
- R1: Bits are shifted in most significant bit first on serial-clock rising edges. The first eight bits after chip select falls form the instruction.
- R2: Instruction 9Fh returns 20h, then 40h, then 14h. Every further byte in the same selection reads 00h.
- R3: Instruction 05h returns a status byte with bit 0 = `seq_busy` and bit 1 = write-enable latch, and all other bits 0. The byte repeats, refreshed, for as long as chip select stays low.
- R4: Instruction 03h is followed by a 24-bit address. Array bytes are then returned from consecutive addresses for as long as chip select stays low. The address wraps within the `ADDR_W`-bit space. The first data bit appears after the falling edge that follows the last address bit.
- R5: Instruction 0Bh behaves like 03h, except that one dummy byte is received after the address and before data.
- R6: 06h sets the write-enable latch and 04h clears it. Each takes effect only when chip select rises after exactly eight bits.
- R7: With the latch set, DBh (page erase, kind 2) or D8h (sector erase, kind 3) plus a 24-bit address, ended after exactly 32 bits, gives a single-cycle `op_valid` with `op_kind` and `op_addr`, and clears the latch. Without the latch, or with a partial byte, nothing is issued.
- R8: With the latch set, 0Ah (page write, kind 0) or 02h (page program, kind 1) plus an address streams every following whole byte on `wr_valid`/`wr_data`. At a byte boundary with at least one data byte received, chip select rising issues the operation and clears the latch.
- R9: While `seq_busy` is high, modifying instructions are rejected: no operation is issued and the latch keeps its value.
- R10: B9h enters deep power-down. Until ABh arrives, every other instruction is ignored: no output, no operation, and no change to the latch.
- R11: `spi_miso_oe` is low while chip select is high and during instruction, address and dummy bits. Output bits change only after serial-clock falling edges.
- R12: An unknown opcode yields no output and no effect until the next falling edge of chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for serial data out (low = high impedance) |
| mem_req | output | 1 | One-cycle array read request |
| mem_addr | output | ADDR_W | Array byte address |
| mem_rdata | input | 8 | Array byte, valid the cycle after `mem_req` |
| seq_busy | input | 1 | Sequencer has a write or erase in progress |
| op_valid | output | 1 | One-cycle operation request to the sequencer |
| op_kind | output | 2 | 0 page write, 1 page program, 2 page erase, 3 sector erase |
| op_addr | output | 24 | Address received with the operation |
| wr_valid | output | 1 | Strobe for one received write/program data byte |
| wr_data | output | 8 | Received write/program data byte |

## Verification
The bench targets the boundaries where a decoder goes subtly wrong. A read started one byte below the top of the array must wrap to address zero; an off-by-one in the increment would return the wrong byte there. A sector erase ended one bit past the address, or a write-enable sent with nine bits, must change nothing; a decoder that checks only the byte count would issue the erase or set the latch. In power-down, a disable instruction must be ignored, which shows up afterwards as a latch that is still set, and an erase must not be issued. Output-enable samples during the command, address and dummy bytes catch a data pin that turns on one byte too early.

// File: rtl/sfcd_pkg.sv
package sfcd_pkg;

   localparam logic [7:0] OPC_WREN  = 8'h06;
   localparam logic [7:0] OPC_WRDI  = 8'h04;
   localparam logic [7:0] OPC_RDID  = 8'h9F;
   localparam logic [7:0] OPC_RDSR  = 8'h05;
   localparam logic [7:0] OPC_READ  = 8'h03;
   localparam logic [7:0] OPC_FAST  = 8'h0B;
   localparam logic [7:0] OPC_PW    = 8'h0A;
   localparam logic [7:0] OPC_PP    = 8'h02;
   localparam logic [7:0] OPC_PE    = 8'hDB;
   localparam logic [7:0] OPC_SE    = 8'hD8;
   localparam logic [7:0] OPC_DP    = 8'hB9;
   localparam logic [7:0] OPC_RDP   = 8'hAB;

   localparam logic [1:0] KIND_PW = 2'd0;
   localparam logic [1:0] KIND_PP = 2'd1;
   localparam logic [1:0] KIND_PE = 2'd2;
   localparam logic [1:0] KIND_SE = 2'd3;

   typedef enum logic [2:0] {
      ST_CMD, ST_ADDR, ST_DUMMY, ST_OUT, ST_WDATA, ST_WAIT, ST_IGNORE
   } sfcd_state_e;

   typedef enum logic [1:0] {
      SRC_MEM, SRC_ID, SRC_STAT
   } sfcd_src_e;

endpackage

// File: rtl/sfcd_pin_sync.sv
module sfcd_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic csn_i,
   input  logic sclk_i,
   input  logic mosi_i,
   output logic cs_hi,
   output logic cs_fall,
   output logic cs_rise,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic mosi_s
);
   localparam logic [2:0] PIN_RST = 3'b100;

   logic [STAGES-1:0][2:0] chain;
   logic [2:0]             last;
   logic [2:0]             prev;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= PIN_RST;
            else        chain <= {csn_i, sclk_i, mosi_i};
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{PIN_RST}};
            else        chain <= {chain[STAGES-2:0], {csn_i, sclk_i, mosi_i}};
         end
      end
   endgenerate

   assign last = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= PIN_RST;
      else        prev <= last;
   end

   assign cs_hi     = last[2];
   assign cs_fall   = ~last[2] &  prev[2];
   assign cs_rise   =  last[2] & ~prev[2];
   assign sclk_rise =  last[1] & ~prev[1];
   assign sclk_fall = ~last[1] &  prev[1];
   assign mosi_s    = last[0];
endmodule

// File: rtl/sfcd_txser.sv
module sfcd_txser #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fall,
   input  logic              load,
   input  logic [BYTE_W-1:0] ld_byte,
   output logic              dout,
   output logic              dout_oe,
   output logic              byte_done
);
   localparam int CW = $clog2(BYTE_W);

   logic [BYTE_W-1:0] sh;
   logic [CW-1:0]     cnt;

   assign byte_done = fall & ~clr & (cnt == CW'(BYTE_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         cnt     <= '0;
         dout    <= 1'b0;
         dout_oe <= 1'b0;
      end else begin
         if (fall && !clr) begin
            dout    <= sh[BYTE_W-1];
            dout_oe <= 1'b1;
            cnt     <= cnt + CW'(1);
         end
         if (clr) begin
            dout_oe <= 1'b0;
            cnt     <= '0;
         end
         if (load)      sh <= ld_byte;
         else if (fall) sh <= {sh[BYTE_W-2:0], 1'b0};
      end
   end
endmodule

// File: rtl/sfcd_mode.sv
module sfcd_mode (
   input  logic clk,
   input  logic rst_n,
   input  logic wel_set,
   input  logic wel_clr,
   input  logic pd_set,
   input  logic pd_clr,
   output logic wel,
   output logic pd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel <= 1'b0;
         pd  <= 1'b0;
      end else begin
         if (wel_clr)      wel <= 1'b0;
         else if (wel_set) wel <= 1'b1;
         if (pd_clr)       pd  <= 1'b0;
         else if (pd_set)  pd  <= 1'b1;
      end
   end
endmodule

// File: rtl/sfcd_front.sv
module sfcd_front
   import sfcd_pkg::*;
#(
   parameter int          ADDR_W      = 20,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  ID_MFR      = 8'h20,
   parameter logic [7:0]  ID_TYPE     = 8'h40,
   parameter logic [7:0]  ID_CAP      = 8'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_csn,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   input  logic              seq_busy,
   output logic              op_valid,
   output logic [1:0]        op_kind,
   output logic [23:0]       op_addr,
   output logic              wr_valid,
   output logic [7:0]        wr_data
);
   localparam int PROTO_AW  = 24;
   localparam int ADDR_BYTES = PROTO_AW / 8;

   generate
      if (ADDR_W < 8 || ADDR_W > PROTO_AW) begin : g_bad_aw
         $error("sfcd_front: ADDR_W must lie in 8..24");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("sfcd_front: SYNC_STAGES must lie in 1..4");
      end
   endgenerate

   logic cs_hi, cs_fall, cs_rise, s_rise, s_fall, mosi_s;
   logic wel, pd;
   logic tx_done, tx_load, start_fetch;
   logic [7:0] tx_byte;

   sfcd_state_e         st;
   sfcd_src_e           src;
   logic [7:0]          op_q;
   logic [PROTO_AW-1:0] addr;
   logic [6:0]          shreg;
   logic [2:0]          bcnt;
   logic [2:0]          nbytes;
   logic [1:0]          id_idx;
   logic                ld_mem_q;

   sfcd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .csn_i(spi_csn), .sclk_i(spi_sclk), .mosi_i(spi_mosi),
      .cs_hi(cs_hi), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .sclk_rise(s_rise), .sclk_fall(s_fall), .mosi_s(mosi_s)
   );

   wire [7:0] in_byte  = {shreg, mosi_s};
   wire       bit_in   = s_rise & ~cs_hi;
   wire       byte_end = bit_in & (bcnt == 3'd7);
   wire       whole    = (bcnt == 3'd0);
   wire       mod_ok   = wel & ~pd & ~seq_busy;
   wire [7:0] stat     = {6'b0, wel, seq_busy};
   wire       out_st   = (st == ST_OUT);

   // decode of the instruction byte
   sfcd_state_e cmd_next;
   sfcd_src_e   cmd_src;
   always_comb begin
      cmd_next = ST_IGNORE;
      cmd_src  = SRC_MEM;
      if (!pd) begin
         case (in_byte)
            OPC_RDID: begin cmd_next = ST_OUT; cmd_src = SRC_ID; end
            OPC_RDSR: begin cmd_next = ST_OUT; cmd_src = SRC_STAT; end
            OPC_READ, OPC_FAST: cmd_next = ST_ADDR;
            OPC_PW, OPC_PP, OPC_PE, OPC_SE: cmd_next = mod_ok ? ST_ADDR : ST_IGNORE;
            default: cmd_next = ST_IGNORE;
         endcase
      end
   end

   sfcd_state_e addr_next;
   always_comb begin
      case (op_q)
         OPC_READ:       addr_next = ST_OUT;
         OPC_FAST:       addr_next = ST_DUMMY;
         OPC_PW, OPC_PP: addr_next = ST_WDATA;
         default:        addr_next = ST_WAIT;
      endcase
   end

   logic [7:0] id_next;
   always_comb begin
      case (id_idx)
         2'd1:    id_next = ID_TYPE;
         2'd2:    id_next = ID_CAP;
         default: id_next = 8'h00;
      endcase
   end

   // output byte sourcing
   always_comb begin
      tx_load     = 1'b0;
      tx_byte     = 8'h00;
      start_fetch = 1'b0;
      if (ld_mem_q) begin
         tx_load = 1'b1;
         tx_byte = mem_rdata;
      end
      if (byte_end && st == ST_CMD && cmd_next == ST_OUT) begin
         tx_load = 1'b1;
         tx_byte = (cmd_src == SRC_ID) ? ID_MFR : stat;
      end
      if (byte_end && ((st == ST_ADDR && nbytes == 3'(ADDR_BYTES) && op_q == OPC_READ)
                       || st == ST_DUMMY))
         start_fetch = 1'b1;
      if (tx_done && out_st) begin
         case (src)
            SRC_MEM: start_fetch = 1'b1;
            SRC_ID:  begin tx_load = 1'b1; tx_byte = id_next; end
            default: begin tx_load = 1'b1; tx_byte = stat; end
         endcase
      end
   end

   // actions taken when chip select rises
   wire one_byte = cs_rise & whole & (nbytes == 3'd1);
   wire issue    = cs_rise & whole &
                   ((st == ST_WAIT  && nbytes == 3'(ADDR_BYTES + 1)) ||
                    (st == ST_WDATA && nbytes >= 3'(ADDR_BYTES + 2)));
   wire wel_set  = one_byte & ~pd & (op_q == OPC_WREN);
   wire wel_clr  = (one_byte & ~pd & (op_q == OPC_WRDI)) | issue;
   wire pd_set   = one_byte & ~pd & (op_q == OPC_DP);
   wire pd_clr   = one_byte &  pd & (op_q == OPC_RDP);

   sfcd_mode u_mode (
      .clk(clk), .rst_n(rst_n),
      .wel_set(wel_set), .wel_clr(wel_clr),
      .pd_set(pd_set), .pd_clr(pd_clr),
      .wel(wel), .pd(pd)
   );

   sfcd_txser #(.BYTE_W(8)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .clr(cs_hi | ~out_st), .fall(s_fall & ~cs_hi & out_st),
      .load(tx_load), .ld_byte(tx_byte),
      .dout(spi_miso), .dout_oe(spi_miso_oe), .byte_done(tx_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IGNORE;
         src      <= SRC_MEM;
         op_q     <= 8'h00;
         addr     <= '0;
         shreg    <= '0;
         bcnt     <= '0;
         nbytes   <= '0;
         id_idx   <= '0;
         mem_req  <= 1'b0;
         ld_mem_q <= 1'b0;
         op_valid <= 1'b0;
         op_kind  <= KIND_PW;
         op_addr  <= '0;
         wr_valid <= 1'b0;
         wr_data  <= 8'h00;
      end else begin
         mem_req  <= start_fetch;
         ld_mem_q <= mem_req;
         wr_valid <= 1'b0;
         op_valid <= issue;
         if (issue) begin
            op_addr <= addr;
            case (op_q)
               OPC_PW:  op_kind <= KIND_PW;
               OPC_PP:  op_kind <= KIND_PP;
               OPC_PE:  op_kind <= KIND_PE;
               default: op_kind <= KIND_SE;
            endcase
         end
         if (mem_req) addr <= addr + PROTO_AW'(1);
         if (tx_done && out_st && src == SRC_ID && id_idx != 2'd3)
            id_idx <= id_idx + 2'd1;
         if (cs_fall) begin
            st     <= ST_CMD;
            bcnt   <= '0;
            nbytes <= '0;
         end else if (bit_in) begin
            shreg <= in_byte[6:0];
            bcnt  <= bcnt + 3'd1;
            if (byte_end) begin
               if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
               case (st)
                  ST_CMD: begin
                     op_q   <= in_byte;
                     st     <= cmd_next;
                     src    <= cmd_src;
                     id_idx <= 2'd1;
                  end
                  ST_ADDR: begin
                     addr <= {addr[PROTO_AW-9:0], in_byte};
                     if (nbytes == 3'(ADDR_BYTES)) st <= addr_next;
                  end
                  ST_DUMMY: st <= ST_OUT;
                  ST_WDATA: begin
                     wr_valid <= 1'b1;
                     wr_data  <= in_byte;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign mem_addr = addr[ADDR_W-1:0];
endmodule

// File: rtl/sfcd_chk.sv
module sfcd_chk (
   input logic clk,
   input logic rst_n,
   input logic spi_csn,
   input logic spi_miso_oe,
   input logic mem_req,
   input logic op_valid,
   input logic wr_valid
);
   logic [2:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               hi_cnt <= '0;
      else if (!spi_csn)        hi_cnt <= '0;
      else if (hi_cnt != 3'd7)  hi_cnt <= hi_cnt + 3'd1;
   end

   assert_hiz_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt == 3'd7) |-> !spi_miso_oe);

   assert_op_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> !op_valid);

   assert_op_on_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> spi_csn);

   assert_fetch_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   assert_wr_while_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !spi_csn);

   assert_wr_op_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && op_valid));
endmodule

bind sfcd_front sfcd_chk u_chk (
   .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_miso_oe(spi_miso_oe),
   .mem_req(mem_req), .op_valid(op_valid), .wr_valid(wr_valid)
);

// File: tb/sim_sfcd_front.sv
`timescale 1ns/1ps
module sim_sfcd_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csn = 1'b1, sclk = 1'b0, mosi = 1'b0, busy = 1'b0;
   logic        miso, miso_oe, mem_req, op_valid, wr_valid;
   logic [19:0] mem_addr;
   logic [7:0]  mem_rdata = 8'h00;
   logic [1:0]  op_kind;
   logic [23:0] op_addr;
   logic [7:0]  wr_data;

   int n_chk = 0, n_bad = 0, n_op = 0, n_wr = 0, cyc = 0;
   logic [1:0]  last_kind = 2'd0;
   logic [23:0] last_addr = '0;
   logic [7:0]  wr_log [64];
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   sfcd_front u0 (
      .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .seq_busy(busy), .op_valid(op_valid), .op_kind(op_kind),
      .op_addr(op_addr), .wr_valid(wr_valid), .wr_data(wr_data)
   );

   function automatic logic [7:0] mf(input logic [19:0] a);
      return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'hA5;
   endfunction

   always @(posedge clk) if (mem_req) mem_rdata <= mf(mem_addr);

   always @(negedge clk) begin
      cyc++;
      if (rst_n && op_valid) begin n_op++; last_kind = op_kind; last_addr = op_addr; end
      if (rst_n && wr_valid) begin wr_log[n_wr % 64] = wr_data; n_wr++; end
      if (cyc == 150000 && !done) begin
         $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
         $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sel();
      csn = 1'b0; tick(6);
   endtask

   task automatic desel();
      tick(6); csn = 1'b1; tick(14);
   endtask

   task automatic bitx(input logic b, output logic r, output logic o);
      mosi = b; tick(6);
      r = miso; o = miso_oe;
      sclk = 1'b1; tick(6); sclk = 1'b0;
   endtask

   task automatic bytex(input logic [7:0] tx, output logic [7:0] rx, output int oen);
      logic r, o;
      rx = 8'h00; oen = 0;
      for (int i = 7; i >= 0; i--) begin
         bitx(tx[i], r, o);
         rx[i] = r;
         if (o) oen++;
      end
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] d; int o;
      sel(); bytex(op, d, o); desel();
   endtask

   task automatic rdsr(output logic [7:0] v, output int oen);
      logic [7:0] d; int o;
      sel(); bytex(8'h05, d, o); bytex(8'h00, v, oen); desel();
   endtask

   task automatic send_addr(input logic [23:0] a);
      logic [7:0] d; int o;
      bytex(a[23:16], d, o); bytex(a[15:8], d, o); bytex(a[7:0], d, o);
   endtask

   task automatic erase(input logic [7:0] op, input logic [23:0] a);
      logic [7:0] d; int o;
      sel(); bytex(op, d, o); send_addr(a); desel();
   endtask

   initial begin
      logic [7:0] d, v;
      int o, o2, op0, wr0;
      logic r, ob;

      tick(5);
      chk("R11 reset oe", {31'b0, miso_oe}, 0);
      chk("R7 reset op_valid", {31'b0, op_valid}, 0);
      chk("R4 reset mem_req", {31'b0, mem_req}, 0);
      rst_n = 1'b1; tick(5);

      // R1 R2 identification, msb first; no drive during the instruction (R11)
      sel(); bytex(8'h9F, d, o);
      chk("R11 oe during instruction", o, 0);
      bytex(8'h00, d, o); chk("R1 R2 id byte0", d, 8'h20); chk("R11 oe on output", o, 8);
      bytex(8'h00, d, o); chk("R2 id byte1", d, 8'h40);
      bytex(8'h00, d, o); chk("R2 id byte2", d, 8'h14);
      bytex(8'h00, d, o); chk("R2 id past end", d, 8'h00);
      desel();
      chk("R11 oe after deselect", {31'b0, miso_oe}, 0);

      // R3 status, R6 enable/disable
      rdsr(v, o); chk("R3 status idle", v, 8'h00);
      cmd1(8'h06);
      sel(); bytex(8'h05, d, o); bytex(8'h00, v, o); bytex(8'h00, d, o2); desel();
      chk("R6 R3 latch set", v, 8'h02); chk("R3 status repeats", d, 8'h02);
      busy = 1'b1; rdsr(v, o); chk("R3 busy bit", v, 8'h03); busy = 1'b0;
      cmd1(8'h04); rdsr(v, o); chk("R6 latch cleared", v, 8'h00);
      sel(); bytex(8'h06, d, o); bitx(1'b0, r, ob); desel();
      rdsr(v, o); chk("R6 nine-bit enable ignored", v, 8'h00);

      // R4 read with wrap of the array space
      sel(); bytex(8'h03, d, o); send_addr(24'h0FFFFE);
      for (int k = 0; k < 4; k++) begin
         bytex(8'h00, d, o);
         chk("R4 read stream", d, mf(20'(20'hFFFFE + k)));
      end
      desel();

      // R5 fast read, dummy byte without drive (R11)
      sel(); bytex(8'h0B, d, o); send_addr(24'h012345);
      chk("R11 oe during address", o, 0);
      bytex(8'h00, d, o); chk("R11 oe during dummy", o, 0);
      for (int k = 0; k < 3; k++) begin
         bytex(8'h00, d, o);
         chk("R5 fast read data", d, mf(20'(20'h12345 + k)));
      end
      desel();

      // R7 erase gating
      op0 = n_op; erase(8'hDB, 24'h003100);
      chk("R7 erase without latch", n_op - op0, 0);
      cmd1(8'h06); op0 = n_op; erase(8'hDB, 24'h003100);
      chk("R7 page erase count", n_op - op0, 1);
      chk("R7 page erase kind", last_kind, 2);
      chk("R7 page erase addr", last_addr, 24'h003100);
      rdsr(v, o); chk("R7 latch cleared by issue", v, 8'h00);
      cmd1(8'h06); op0 = n_op;
      sel(); bytex(8'hD8, d, o); send_addr(24'h070000); bitx(1'b1, r, ob); desel();
      chk("R7 partial byte sector erase", n_op - op0, 0);
      rdsr(v, o); chk("R7 latch kept on partial", v, 8'h02);
      erase(8'hD8, 24'h070000);
      chk("R7 sector erase kind", last_kind, 3);
      chk("R7 sector erase count", n_op - op0, 1);

      // R8 program and write with data stream
      cmd1(8'h06); op0 = n_op; wr0 = n_wr;
      sel(); bytex(8'h02, d, o); send_addr(24'h0ABCDE);
      bytex(8'h11, d, o); bytex(8'h22, d, o); bytex(8'h33, d, o); desel();
      chk("R8 program bytes", n_wr - wr0, 3);
      chk("R8 program data", {wr_log[wr0 % 64], wr_log[(wr0 + 1) % 64], wr_log[(wr0 + 2) % 64]}, 24'h112233);
      chk("R8 program kind", last_kind, 1);
      chk("R8 program addr", last_addr, 24'h0ABCDE);
      cmd1(8'h06); op0 = n_op;
      sel(); bytex(8'h0A, d, o); send_addr(24'h000100); bytex(8'h5C, d, o); desel();
      chk("R8 page write issued", n_op - op0, 1);
      chk("R8 page write kind", last_kind, 0);
      cmd1(8'h06); op0 = n_op;
      sel(); bytex(8'h0A, d, o); send_addr(24'h000100); desel();
      chk("R8 write without data", n_op - op0, 0);
      cmd1(8'h04);

      // R9 busy rejection
      cmd1(8'h06); busy = 1'b1; op0 = n_op; erase(8'hDB, 24'h000200); busy = 1'b0;
      chk("R9 busy rejects erase", n_op - op0, 0);
      rdsr(v, o); chk("R9 latch kept", v, 8'h02);

      // R10 deep power-down
      cmd1(8'hB9);
      rdsr(v, o); chk("R10 status silent in power-down", o, 0);
      cmd1(8'h04); op0 = n_op; erase(8'hDB, 24'h000300);
      chk("R10 erase ignored", n_op - op0, 0);
      cmd1(8'hAB);
      rdsr(v, o); chk("R10 latch untouched by disable", v, 8'h02);
      erase(8'hDB, 24'h000300);
      chk("R10 erase after release", n_op - op0, 1);

      // R12 unknown opcode
      sel(); bytex(8'h5A, d, o); bytex(8'h00, d, o); bytex(8'h00, d, o2); desel();
      chk("R12 unknown silent", o + o2, 0);
      rdsr(v, o); chk("R12 unknown no effect", v, 8'h00);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule